// File: doc/BRIEF.md
# Calibrated DAC Code Register Bank

This block holds the digital code path of a multi-channel voltage DAC. For every channel it keeps two raw input words (bank A and bank B), a gain trim word and an offset trim word. It also keeps two calibrated words, one per bank, and the code that is finally presented to the converter. A single multiply-add engine is shared by all channels. It turns a raw word into a calibrated word whenever the raw word or one of the trims of that channel changes.

Software-side logic writes through one parallel port that carries a channel number, a register kind and a data word. A global bank bit steers input and trim writes to bank A or bank B. Per-channel route bits, held in groups of eight, pick which calibrated word a channel presents. A falling edge on the active-low load strobe copies the routed calibrated word of every channel into its output register at the same moment. Recomputations wait in a pending set and are served one at a time. `busy` stays high until that set is empty, and a load strobe that falls while work is pending is held back until the engine is idle.

Top module: `dac_cal_bank`

## Requirements
- R1: After reset every output code is 8192, `busy` is low, the bank bit and all route bits are 0, gain words are 16383, offset words are 8192 and both raw words of every channel are 8192.
- R2: A write with kind 0 (input) stores `wr_data` into bank A's raw word of channel `wr_chan` when the bank bit is 0, and into bank B's raw word when it is 1. The other bank's raw word is left unchanged. Kind 3 sets the bank bit to `wr_data[0]`.
- R3: A calibrated word equals floor(raw × (gain + 1) / 16384) + offset − 8192, clamped to the range 0 to 16383.
- R4: Writing the gain word (kind 1) or the offset word (kind 2) of a channel recomputes only that channel's calibrated word in the bank named by the bank bit. The other bank's calibrated word keeps its previous value.
- R5: Recomputations are served one at a time, and each one takes exactly two clock cycles. `busy` is high from the cycle after an input or trim write until the last pending recomputation has been written. A burst of N writes to distinct channels keeps `busy` high for exactly 2·N cycles.
- R6: Kind 4 loads `wr_data[7:0]` into the route bits of group `wr_chan / 8`. Bit n of that field routes channel 8·group + n. A route bit of 0 presents the bank A calibrated word and a route bit of 1 presents the bank B word.
- R7: Kind 5 sets every route bit of every group to `wr_data[0]`.
- R8: Output codes change only on a load. A falling edge of `ldac_n` seen while idle updates all channels on that same clock edge.
- R9: A falling edge of `ldac_n` seen while `busy` is high changes no output. The load then happens on the first clock edge at which `busy` is low, using the recomputed words.
- R10: Writes with kind 6 or 7 change no register, and no output code changes at the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the parallel port |
| wr_chan | input | $clog2(NCH) | Channel number, or group selector for kind 4 |
| wr_kind | input | 3 | Register kind: 0 input, 1 gain, 2 offset, 3 bank bit, 4 group route, 5 route all |
| wr_data | input | 14 | Write data word |
| ldac_n | input | 1 | Active-low load strobe, acts on its falling edge |
| busy | output | 1 | Recomputations pending or in progress |
| dac_out | output | NCH*14 | Output codes, channel i in bits [14i+13:14i] |

## Verification
The bench builds the block with its default values: sixteen channels in two groups of eight with 14-bit codes. At this size every channel and both route groups can be visited on each pass. Each output is compared after every load against a model that keeps its own copy of all raw, trim and calibrated words. The arithmetic sweep walks all channels with spread-out raw, gain and offset values and adds the clamping corners at both ends. A four-write burst with the strobe dropped halfway through gives an exact busy length and shows the deferred load.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;
  localparam int DW = 14;

  typedef enum logic [2:0] {
    K_INPUT = 3'd0,
    K_GAIN  = 3'd1,
    K_OFFS  = 3'd2,
    K_BANK  = 3'd3,
    K_GSEL  = 3'd4,
    K_ASEL  = 3'd5
  } kind_e;

  // First stage: raw * (gain + 1) / 2^DW
  function automatic logic [DW:0] cal_scale(logic [DW-1:0] x, logic [DW-1:0] m);
    logic [2*DW:0] p;
    p = (2*DW+1)'(x) * (2*DW+1)'({1'b0, m} + (DW+1)'(1));
    return p[2*DW:DW];
  endfunction

  // Second stage: add offset, remove mid-scale, clamp to code range
  function automatic logic [DW-1:0] cal_trim(logic [DW:0] s, logic [DW-1:0] c);
    logic signed [DW+2:0] t;
    t = $signed({2'b00, s}) + $signed({3'b000, c}) - $signed((DW+3)'(1 << (DW-1)));
    if (t < 0) return '0;
    else if (t > $signed((DW+3)'((1 << DW) - 1))) return '1;
    else return t[DW-1:0];
  endfunction
endpackage

// File: rtl/dac_cal_queue.sv
module dac_cal_queue #(
  parameter int NSLOT = 32,
  localparam int QW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] set_vec,
  input  logic             take,
  output logic             pend_any,
  output logic [QW-1:0]    pick_idx
);
  logic [NSLOT-1:0] pend_q;
  logic [NSLOT-1:0] clr_vec;

  always_comb begin
    pick_idx = '0;
    for (int i = NSLOT-1; i >= 0; i--)
      if (pend_q[i]) pick_idx = QW'(i);
  end

  always_comb begin
    clr_vec = '0;
    if (take) clr_vec[pick_idx] = 1'b1;
  end

  assign pend_any = |pend_q;

  // a new request for the slot being taken wins over the clear
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | set_vec;
  end

  p_take_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_q[pick_idx]);
endmodule

// File: rtl/dac_cal_engine.sv
module dac_cal_engine import dac_cal_pkg::*; #(
  parameter int QW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [QW-1:0] idx_in,
  input  logic [DW-1:0] op_x,
  input  logic [DW-1:0] op_m,
  input  logic [DW-1:0] op_c,
  output logic          active,
  output logic          finish,
  output logic [QW-1:0] fin_idx,
  output logic [DW-1:0] result
);
  logic [DW:0]   scale_q;
  logic [DW-1:0] c_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      fin_idx <= '0;
      scale_q <= '0;
      c_q     <= '0;
    end else begin
      active <= start;
      if (start) begin
        fin_idx <= idx_in;
        scale_q <= cal_scale(op_x, op_m);
        c_q     <= op_c;
      end
    end
  end

  assign finish = active;
  assign result = cal_trim(scale_q, c_q);

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  p_two_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> finish);
endmodule

// File: rtl/dac_cal_bank.sv
module dac_cal_bank import dac_cal_pkg::*; #(
  parameter int NCH = 16,
  parameter int GRP = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NCH)-1:0]  wr_chan,
  input  logic [2:0]              wr_kind,
  input  logic [DW-1:0]           wr_data,
  input  logic                    ldac_n,
  output logic                    busy,
  output logic [NCH*DW-1:0]       dac_out
);
  localparam int CW = $clog2(NCH);
  localparam int NG = NCH / GRP;
  localparam int QW = CW + 1;
  localparam logic [DW-1:0] MID_CODE = DW'(1 << (DW-1));
  localparam logic [DW-1:0] TOP_CODE = DW'((1 << DW) - 1);

  logic [NCH-1:0][DW-1:0] x1a, x1b, m_q, c_q, x2a, x2b, dac_q;
  logic [NCH-1:0]         sel_q;
  logic                   bank_q;
  logic                   ldac_q, ld_req;

  kind_e kind;
  assign kind = kind_e'(wr_kind);

  // named events for the checks
  logic wr_input, wr_trim, ld_fall, do_load;
  logic pend_any, eng_start, eng_active, eng_finish;
  logic [QW-1:0] pick_idx, fin_idx;
  logic [2*NCH-1:0] set_vec;
  logic [DW-1:0] op_x, eng_res;
  logic [CW-1:0] pick_ch, fin_ch;

  assign wr_input = wr_en && (kind == K_INPUT);
  assign wr_trim  = wr_en && (kind == K_GAIN || kind == K_OFFS);

  always_comb begin
    set_vec = '0;
    if (wr_input || wr_trim) set_vec[{bank_q, wr_chan}] = 1'b1;
  end

  dac_cal_queue #(.NSLOT(2*NCH)) u_queue (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .take(eng_start),
    .pend_any(pend_any), .pick_idx(pick_idx)
  );

  assign eng_start = pend_any && !eng_active;
  assign pick_ch   = pick_idx[CW-1:0];
  assign op_x      = pick_idx[CW] ? x1b[pick_ch] : x1a[pick_ch];

  dac_cal_engine #(.QW(QW)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .idx_in(pick_idx),
    .op_x(op_x), .op_m(m_q[pick_ch]), .op_c(c_q[pick_ch]),
    .active(eng_active), .finish(eng_finish), .fin_idx(fin_idx), .result(eng_res)
  );

  assign fin_ch = fin_idx[CW-1:0];
  assign busy   = pend_any || eng_active;

  // user-visible registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x1a    <= {NCH{MID_CODE}};
      x1b    <= {NCH{MID_CODE}};
      m_q    <= {NCH{TOP_CODE}};
      c_q    <= {NCH{MID_CODE}};
      sel_q  <= '0;
      bank_q <= 1'b0;
    end else if (wr_en) begin
      case (kind)
        K_INPUT: if (bank_q) x1b[wr_chan] <= wr_data;
                 else        x1a[wr_chan] <= wr_data;
        K_GAIN:  m_q[wr_chan] <= wr_data;
        K_OFFS:  c_q[wr_chan] <= wr_data;
        K_BANK:  bank_q <= wr_data[0];
        K_GSEL:  for (int g = 0; g < NG; g++)
                   if (int'(wr_chan) / GRP == g) sel_q[g*GRP +: GRP] <= wr_data[GRP-1:0];
        K_ASEL:  sel_q <= {NCH{wr_data[0]}};
        default: ;
      endcase
    end
  end

  // calibrated copies, written only by the engine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x2a <= {NCH{MID_CODE}};
      x2b <= {NCH{MID_CODE}};
    end else if (eng_finish) begin
      if (fin_idx[CW]) x2b[fin_ch] <= eng_res;
      else             x2a[fin_ch] <= eng_res;
    end
  end

  // load strobe, held back while work is pending
  assign ld_fall = ldac_q && !ldac_n;
  assign do_load = (ld_fall || ld_req) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldac_q <= 1'b1;
      ld_req <= 1'b0;
      dac_q  <= {NCH{MID_CODE}};
    end else begin
      ldac_q <= ldac_n;
      ld_req <= (ld_fall || ld_req) && busy;
      if (do_load)
        for (int i = 0; i < NCH; i++) dac_q[i] <= sel_q[i] ? x2b[i] : x2a[i];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_out
    assign dac_out[i*DW +: DW] = dac_q[i];
  end

  p_bank_a_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_input && !bank_q) |=> $stable(x1b));
  p_bank_b_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_input && bank_q) |=> $stable(x1a));
  p_x2_engine_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_finish |=> ($stable(x2a) && $stable(x2b)));
  p_busy_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_input || wr_trim) |=> busy);
  p_route_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == K_ASEL) |=> (sel_q == '0 || sel_q == '1));
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !do_load |=> $stable(dac_out));
  p_load_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |-> (!pend_any && !eng_active));
  p_defer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && busy) |=> ld_req);
endmodule

// File: tb/sim_dac_cal_bank.sv
`timescale 1ns/1ps
module sim_dac_cal_bank;
  localparam int NCH = 16;
  localparam int DW  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_chan = '0;
  logic [2:0] wr_kind = '0;
  logic [DW-1:0] wr_data = '0;
  logic ldac_n = 1'b1;
  logic busy;
  logic [NCH*DW-1:0] dac_out;

  always #2.5 clk = ~clk;

  dac_cal_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_kind(wr_kind), .wr_data(wr_data), .ldac_n(ldac_n),
    .busy(busy), .dac_out(dac_out)
  );

  int n_chk = 0;
  int n_err = 0;

  // bench model
  int mx1a[NCH], mx1b[NCH], mm[NCH], mc[NCH], mx2a[NCH], mx2b[NCH], mfin[NCH];
  bit msel[NCH];
  bit mbank;

  function automatic int exp_cal(int x, int m, int c);
    int v;
    v = (x * (m + 1)) / 16384 + c - 8192;
    if (v < 0) v = 0;
    if (v > 16383) v = 16383;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NCH; i++) begin
      int a;
      a = int'(dac_out[i*DW +: DW]);
      chk(a == mfin[i], tag, a, mfin[i]);
    end
  endtask

  function automatic void recompute(int ch);
    if (mbank) mx2b[ch] = exp_cal(mx1b[ch], mm[ch], mc[ch]);
    else       mx2a[ch] = exp_cal(mx1a[ch], mm[ch], mc[ch]);
  endfunction

  // drive one write at a negedge, it is sampled at the next posedge
  task automatic drive(int kind, int ch, int data);
    wr_en = 1'b1; wr_kind = 3'(kind); wr_chan = 4'(ch); wr_data = DW'(data);
    case (kind)
      0: begin if (mbank) mx1b[ch] = data; else mx1a[ch] = data; recompute(ch); end
      1: begin mm[ch] = data; recompute(ch); end
      2: begin mc[ch] = data; recompute(ch); end
      3: mbank = data[0];
      4: for (int n = 0; n < 8; n++) msel[(ch / 8) * 8 + n] = data[n];
      5: for (int i = 0; i < NCH; i++) msel[i] = data[0];
      default: ;
    endcase
  endtask

  task automatic wr(int kind, int ch, int data);
    @(negedge clk);
    drive(kind, ch, data);
    @(negedge clk);
    wr_en = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic pulse(string tag);
    @(negedge clk); ldac_n = 1'b0;
    @(negedge clk); ldac_n = 1'b1;
    for (int i = 0; i < NCH; i++) mfin[i] = msel[i] ? mx2b[i] : mx2a[i];
    check_all(tag);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      mx1a[i] = 8192; mx1b[i] = 8192; mm[i] = 16383; mc[i] = 8192;
      mx2a[i] = 8192; mx2b[i] = 8192; mfin[i] = 8192; msel[i] = 1'b0;
    end
    mbank = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1 reset output");
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    pulse("R1 reset words after load");

    // R3 arithmetic sweep over all channels, bank A
    for (int i = 0; i < 24; i++) begin
      int ch;
      ch = i % NCH;
      wr(1, ch, (i * 7919 + 11) % 16384);
      wr(2, ch, (i * 3001 + 100) % 16384);
      wr(0, ch, (i * 2731 + 5) % 16384);
      pulse("R3 sweep");
    end
    // R3 clamping corners
    wr(1, 2, 16383); wr(2, 2, 16383); wr(0, 2, 16383);
    pulse("R3 clamp high");
    wr(2, 2, 0); wr(0, 2, 0);
    pulse("R3 clamp low");
    wr(2, 2, 8192); wr(0, 2, 0);
    pulse("R3 zero boundary");
    wr(1, 2, 0); wr(2, 2, 8191); wr(0, 2, 16383);
    pulse("R3 gain one");

    // R2 bank steering; R6 group route
    wr(3, 0, 1);
    wr(0, 3, 1234);
    pulse("R2 bank B write leaves A");
    wr(4, 0, 8'h08);
    pulse("R6 group 0 bit 3");
    wr(4, 8, 8'h04);
    wr(0, 10, 15000);
    pulse("R6 group 1 bit 2");

    // R4 trim write recomputes only the chosen bank
    wr(1, 5, 9000);
    wr(5, 0, 0);
    pulse("R4 bank A untouched");
    wr(5, 0, 1);
    pulse("R7 route all to B");
    wr(3, 0, 0);
    wr(2, 5, 100);
    pulse("R4 bank B untouched");
    wr(5, 0, 0);
    pulse("R7 route all to A");

    // R8 no load, no change
    wr(0, 7, 42);
    wr(1, 7, 5000);
    @(negedge clk);
    check_all("R8 hold without strobe");

    // R10 unused kinds
    wr(6, 1, 777);
    wr(7, 4, 3333);
    pulse("R10 unused kinds");

    // R5 burst and R9 deferred load
    begin
      int bcnt;
      bcnt = 0;
      @(negedge clk);
      drive(0, 12, 100);
      for (int j = 1; j < 4; j++) begin
        @(negedge clk);
        if (busy) bcnt++;
        drive(0, 12 + j, 100 + 4000 * j);
      end
      @(negedge clk);
      if (busy) bcnt++;
      wr_en = 1'b0;
      ldac_n = 1'b0;
      @(negedge clk);
      if (busy) bcnt++;
      check_all("R9 no load while busy");
      while (busy) begin
        @(negedge clk);
        if (busy) bcnt++;
      end
      ldac_n = 1'b1;
      chk(bcnt == 8, "R5 busy length", bcnt, 8);
      @(negedge clk);
      for (int i = 0; i < NCH; i++) mfin[i] = msel[i] ? mx2b[i] : mx2a[i];
      check_all("R9 deferred load");
    end

    finish_run();
  end
endmodule